// File: doc/BRIEF.md
# Cycle-Stealing Shared RAM Arbiter

This block sits in front of a single-port 128-byte RAM that an internal processor uses as its working store. An external host reaches the same RAM through a plain static read/write port. Every host access is served on the cycle it is presented: the host borrows that one RAM cycle and the processor's grant drops for it. The host never waits, so its accesses may follow one another on consecutive cycles. The processor holds its request until it sees a grant.

Only 41 of the 128 addresses are visible to the host. Addresses 0x00 to 0x27 are 40 direct registers, and one of them (0x04) holds a channel selection. Address 0x28 is a window onto FIFO storage. Everything else is private to the processor. The FIFO window is steered by the processor side. While the service flag is high, window accesses walk through the FIFO of the channel being serviced. The channel value the host wrote at 0x04 plays no part in this.

A counter tallies stolen cycles over a window whose length is set on a port. The tally, a done pulse and an over-ten-percent flag are reported at the end of each window.

Top module: `shared_ram_arbiter`

## Requirements
- R1: After reset, `h_rvalid`, `p_rvalid`, `win_done` and `steal_cnt` are zero, and `p_gnt` is low while `p_req` is low.
- R2: Host accesses to addresses 0x00–0x27 read and write the RAM. Accesses may be presented on consecutive cycles with no gap. Read data appears with `h_rvalid` high in the cycle after the access.
- R3: When `h_sel` and `p_req` are both high, `p_gnt` is low and the processor's write does not take effect. The host's write does take effect.
- R4: With `h_sel` low, a `p_req` is granted in the same cycle. The processor can read and write any of the 128 addresses, and its read data appears with `p_rvalid` the cycle after.
- R5: A host access to an address above 0x28 reads 0x00. A host write to such an address leaves the RAM unchanged.
- R6: While `svc_active` is high, host accesses to 0x28 reach RAM address 0x60 + 4·`svc_chan` + k. The offset k starts at 0 on each rising edge of `svc_active`, advances by one per window access, and wraps after 3.
- R7: A host write to the channel register at 0x04 does not change which RAM bytes the 0x28 window reaches.
- R8: While `svc_active` is low, a host read of 0x28 returns 0x00 and a host write to 0x28 changes nothing.
- R9: The window lasts `win_len` cycles. At its end, `win_done` pulses for one cycle and `steal_cnt` holds the number of cycles in which `h_sel` was high. `duty_hi` is 1 exactly when 10·`steal_cnt` > `win_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host access this cycle |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | 7 | Host address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| h_rvalid | output | 1 | Host read data valid |
| p_req | input | 1 | Processor bus request |
| p_wr | input | 1 | Processor access is a write |
| p_addr | input | 7 | Processor address |
| p_wdata | input | 8 | Processor write data |
| p_gnt | output | 1 | Processor granted this cycle |
| p_rdata | output | 8 | Processor read data |
| p_rvalid | output | 1 | Processor read data valid |
| svc_active | input | 1 | Service request in progress |
| svc_chan | input | 3 | Channel being serviced |
| win_len | input | 16 | Measurement window length in cycles |
| steal_cnt | output | 16 | Stolen cycles in the last window |
| win_done | output | 1 | One-cycle pulse at window end |
| duty_hi | output | 1 | Last window's host share exceeded 10% |

## Verification
The assertions assume that `svc_active` and `svc_chan` change only between service windows. They also assume `svc_chan` stays constant while the flag is high, and that `win_len` is at least one and never changes. The bench drives all inputs on the falling edge and raises the service flag only after at least one idle cycle. It holds the channel fixed for the whole service, and it ties `win_len` to 20. Window measurements are taken only after a `win_done` pulse has been seen, so the counted host cycles fall inside a known window.

// File: rtl/shared_ram_arbiter.sv
module shared_ram_arbiter #(
  parameter int AW         = 7,
  parameter int DW         = 8,
  parameter int NREG       = 40,
  parameter int CHANS      = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int FIFO_BASE  = 96,
  parameter int WCW        = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     h_sel,
  input  logic                     h_wr,
  input  logic [AW-1:0]            h_addr,
  input  logic [DW-1:0]            h_wdata,
  output logic [DW-1:0]            h_rdata,
  output logic                     h_rvalid,
  input  logic                     p_req,
  input  logic                     p_wr,
  input  logic [AW-1:0]            p_addr,
  input  logic [DW-1:0]            p_wdata,
  output logic                     p_gnt,
  output logic [DW-1:0]            p_rdata,
  output logic                     p_rvalid,
  input  logic                     svc_active,
  input  logic [$clog2(CHANS)-1:0] svc_chan,
  input  logic [WCW-1:0]           win_len,
  output logic [WCW-1:0]           steal_cnt,
  output logic                     win_done,
  output logic                     duty_hi
);
  localparam int DEPTH    = 1 << AW;
  localparam int WIN_ADDR = NREG;
  localparam int OW       = $clog2(FIFO_DEPTH);

  logic [DW-1:0]  mem [DEPTH];
  logic [DW-1:0]  rd_q;
  logic           h_rv, h_zero, p_rv, svc_q;
  logic [OW-1:0]  off, off_eff;
  logic [WCW-1:0] win_cyc, steal_run, steal_total;
  logic [AW-1:0]  fifo_addr, bus_addr;
  logic [DW-1:0]  bus_wd;
  logic           h_direct, h_window, win_ok, h_hit, svc_rise, bus_we, win_end;
  logic [WCW+3:0] share_x10;

  assign h_direct  = h_addr < AW'(NREG);
  assign h_window  = h_addr == AW'(WIN_ADDR);
  assign win_ok    = h_window && svc_active;
  assign h_hit     = h_direct || win_ok;
  assign svc_rise  = svc_active && !svc_q;
  assign off_eff   = svc_rise ? '0 : off;
  assign fifo_addr = AW'(FIFO_BASE + FIFO_DEPTH * int'(svc_chan) + int'(off_eff));

  assign p_gnt    = p_req && !h_sel;
  assign bus_addr = h_sel ? (h_window ? fifo_addr : h_addr) : p_addr;
  assign bus_we   = h_sel ? (h_wr && h_hit) : (p_gnt && p_wr);
  assign bus_wd   = h_sel ? h_wdata : p_wdata;

  always_ff @(posedge clk) begin
    if (bus_we) mem[bus_addr] <= bus_wd;
    rd_q <= mem[bus_addr];
  end

  assign h_rvalid = h_rv;
  assign h_rdata  = (h_rv && !h_zero) ? rd_q : '0;
  assign p_rvalid = p_rv;
  assign p_rdata  = p_rv ? rd_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rv   <= 1'b0;
      h_zero <= 1'b0;
      p_rv   <= 1'b0;
      svc_q  <= 1'b0;
      off    <= '0;
    end else begin
      h_rv   <= h_sel && !h_wr;
      h_zero <= !h_hit;
      p_rv   <= p_gnt && !p_wr;
      svc_q  <= svc_active;
      if (h_sel && win_ok) off <= off_eff + OW'(1);
      else if (svc_rise)   off <= '0;
    end
  end

  assign steal_total = steal_run + WCW'(h_sel);
  assign win_end     = ({1'b0, win_cyc} + (WCW+1)'(1)) >= {1'b0, win_len};
  assign share_x10   = (WCW+4)'(steal_total) * (WCW+4)'(10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cyc   <= '0;
      steal_run <= '0;
      steal_cnt <= '0;
      win_done  <= 1'b0;
      duty_hi   <= 1'b0;
    end else begin
      win_done <= win_end;
      if (win_end) begin
        win_cyc   <= '0;
        steal_run <= '0;
        steal_cnt <= steal_total;
        duty_hi   <= share_x10 > (WCW+4)'(win_len);
      end else begin
        win_cyc   <= win_cyc + WCW'(1);
        steal_run <= steal_total;
      end
    end
  end

  // R3: a stolen cycle never yields processor read data
  a_r3_host_excludes_proc: assert property (@(posedge clk) disable iff (!rst_n)
    h_sel |=> !p_rvalid);

  // R4: a granted processor read returns data next cycle, host silent
  a_r4_proc_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (p_gnt && !p_wr) |=> (p_rvalid && !h_rvalid));

  // R5: private addresses read as zero
  a_r5_private_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && !h_wr && !h_direct && !h_window) |=> (h_rvalid && h_rdata == '0));

  // R8: window with no service reads zero
  a_r8_idle_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && !h_wr && h_window && !svc_active) |=> (h_rdata == '0));

  // R6: offset restarts when service begins
  a_r6_ptr_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(svc_active) && !(h_sel && h_window)) |=> (off == '0));

  // R9: stolen tally cannot outrun elapsed cycles
  a_r9_tally_bound: assert property (@(posedge clk) disable iff (!rst_n)
    steal_run <= win_cyc);
endmodule

// File: tb/tb_shared_ram_arbiter.sv
module tb_shared_ram_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int WLEN = 20;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       h_sel = 0, h_wr = 0, p_req = 0, p_wr = 0, svc_active = 0;
  logic [6:0] h_addr = 0, p_addr = 0;
  logic [7:0] h_wdata = 0, p_wdata = 0;
  logic [2:0] svc_chan = 0;
  logic [7:0] h_rdata, p_rdata;
  logic       h_rvalid, p_rvalid, p_gnt, win_done, duty_hi;
  logic [15:0] steal_cnt;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] hm [128];
  int bo = 0;

  shared_ram_arbiter dut (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid), .p_req(p_req),
    .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata), .p_gnt(p_gnt),
    .p_rdata(p_rdata), .p_rvalid(p_rvalid), .svc_active(svc_active),
    .svc_chan(svc_chan), .win_len(16'(WLEN)), .steal_cnt(steal_cnt),
    .win_done(win_done), .duty_hi(duty_hi));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && h_rvalid) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected read data", int'(h_rdata), 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(h_rdata == e, t, int'(h_rdata), int'(e));
      end
    end
  end

  function automatic int win_target();
    return 96 + 4 * int'(svc_chan) + bo;
  endfunction

  task automatic host_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    h_sel = 1; h_wr = 1; h_addr = 7'(a); h_wdata = d; p_req = 0;
    if (a < 40) hm[a] = d;
    else if (a == 40 && svc_active) begin hm[win_target()] = d; bo = (bo + 1) % 4; end
  endtask

  task automatic host_rd(input int a, input string tag);
    @(negedge clk);
    h_sel = 1; h_wr = 0; h_addr = 7'(a); p_req = 0;
    if (a < 40) exp_q.push_back(hm[a]);
    else if (a == 40 && svc_active) begin exp_q.push_back(hm[win_target()]); bo = (bo + 1) % 4; end
    else exp_q.push_back(8'h00);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    h_sel = 0; h_wr = 0; p_req = 0; p_wr = 0;
  endtask

  task automatic proc_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    h_sel = 0; p_req = 1; p_wr = 1; p_addr = 7'(a); p_wdata = d;
    #1 chk(p_gnt == 1'b1, "R4 grant when host idle", int'(p_gnt), 1);
    hm[a] = d;
  endtask

  task automatic proc_rd(input int a, input logic [7:0] e, input string tag);
    @(negedge clk);
    h_sel = 0; p_req = 1; p_wr = 0; p_addr = 7'(a);
    #1 chk(p_gnt == 1'b1, "R4 grant on read", int'(p_gnt), 1);
    @(negedge clk);
    chk(p_rvalid && p_rdata == e, tag, int'(p_rdata), int'(e));
    p_req = 0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(h_rvalid == 0 && p_rvalid == 0, "R1 valids low after reset", int'({h_rvalid, p_rvalid}), 0);
    chk(p_gnt == 0 && win_done == 0 && steal_cnt == 0, "R1 counter and grant idle",
        int'(steal_cnt), 0);

    // R2: back-to-back writes then reads
    for (int i = 0; i < 8; i++) host_wr(i * 5, 8'(8'h10 + i * 7));
    for (int i = 0; i < 8; i++) host_rd(i * 5, "R2 back-to-back read");
    host_rd(0, "R2 read after read");
    idle();

    // R4: processor write visible to host
    proc_wr(7, 8'h5C);
    idle();
    host_rd(7, "R4 proc write seen by host");
    idle();
    proc_rd(5, hm[5], "R4 proc read of host data");

    // R3: same-cycle conflict, host wins
    @(negedge clk);
    h_sel = 1; h_wr = 1; h_addr = 7'd3; h_wdata = 8'h33; hm[3] = 8'h33;
    p_req = 1; p_wr = 1; p_addr = 7'd3; p_wdata = 8'h99;
    #1 chk(p_gnt == 0, "R3 grant dropped on conflict", int'(p_gnt), 0);
    idle();
    host_rd(3, "R3 host write kept, proc write dropped");
    idle();

    // R5: private addresses
    proc_wr(80, 8'h11);
    host_wr(80, 8'h77);
    host_rd(80, "R5 private read zero");
    idle();
    proc_rd(80, 8'h11, "R5 host write ignored");

    // R7 + R6: channel register vs serviced channel
    host_wr(4, 8'h05);
    idle();
    @(negedge clk); svc_chan = 3'd2; svc_active = 1; bo = 0;
    for (int i = 0; i < 5; i++) host_wr(40, 8'(8'hA0 + i));
    host_rd(40, "R6 window read at wrapped offset");
    host_rd(4, "R7 channel register holds host value");
    idle();
    @(negedge clk); svc_active = 0;
    proc_rd(104, 8'hA4, "R6 wrap overwrote offset 0");
    proc_rd(105, 8'hA1, "R6 offset 1 of serviced channel");
    proc_rd(107, 8'hA3, "R6 offset 3 of serviced channel");
    proc_wr(116, 8'h5A);
    proc_rd(116, 8'h5A, "R7 channel 5 FIFO untouched");

    // R8: window without service
    host_wr(40, 8'hEE);
    host_rd(40, "R8 idle window reads zero");
    idle();
    proc_rd(104, 8'hA4, "R8 idle window write ignored");

    // R6: restart on new service
    @(negedge clk); svc_active = 1; bo = 0;
    host_rd(40, "R6 offset restarts on new service");
    idle();
    @(negedge clk); svc_active = 0;

    // R9: window tally
    for (int n = 1; n <= 3; n++) begin
      do @(negedge clk); while (!win_done);
      for (int k = 0; k < n; k++) host_rd(0, "R9 filler read");
      idle();
      do @(negedge clk); while (!win_done);
      chk(steal_cnt == 16'(n), "R9 stolen cycle count", int'(steal_cnt), n);
      chk(duty_hi == (n * 10 > WLEN), "R9 duty flag", int'(duty_hi), int'(n * 10 > WLEN));
      @(negedge clk);
      chk(win_done == 0, "R9 done is one cycle", int'(win_done), 0);
    end

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
    report();
  end
endmodule